// File: doc/BRIEF.md
# Boot-Remapping System Address Decoder

This block steers every access on a 32-bit system bus to exactly one target: the on-chip boot ROM, the on-chip scratch SRAM, one of six static-memory chip selects, one of two dynamic-memory controllers, or the peripheral bus. It also reduces the address to a byte offset local to that target. Unsupported accesses raise an error flag instead of a select. The lowest 128 MB has no storage of its own. Accesses there are forwarded to the ROM or to the SRAM, depending on the boot mode. The boot mode is captured while reset is held.

The two on-chip memories are far smaller than their address windows, so the decoder folds each window onto the real storage. The offset is the address modulo the memory size. A static chip select that is routed to a NAND or CF controller cannot be reached through the static region, with one exception. When chip select 2 carries NAND, its window becomes a mirror of the scratch SRAM.

Each decision is registered when the valid strobe is high. The result is then held until the next strobe.

Top module: `sys_addr_decoder`

## Requirements
- R1: While reset is low at a clock edge, the select output is all zero, the offset is zero and the error flag is low on the following cycle.
- R2: Select bit encoding: bit 0 ROM, bit 1 SRAM, bits 2..7 static chip selects 0..5, bit 8 dynamic controller 0, bit 9 dynamic controller 1, bit 10 peripheral bus. The peripheral bus decodes 0x7000_0000–0x7FFF_FFFF with offset = address − 0x7000_0000.
- R3: In 0x0000_0000–0x07FF_FFFF the access goes to the ROM when the captured boot mode is 0, and to the SRAM when it is 1. The offset is folded to the size of the chosen memory.
- R4: The ROM decodes at 0x0800_0000–0x0BFF_FFFF with offset = address mod 32 KB. A write that resolves to the ROM, directly or through the boot window, sets the error flag.
- R5: The SRAM decodes at 0x0C00_0000–0x0FFF_FFFF with offset = address mod 4 KB. Both reads and writes are accepted.
- R6: The static region 0x1000_0000–0x3FFF_FFFF is cut into six 128 MB windows. Chip select n starts at 0x1000_0000 + n·0x0800_0000, and the offset is the address mod 128 MB.
- R7: If chip select 2..5 has its NAND flag or its CF flag set, an access to its window sets the error flag. The flags of chip selects 0 and 1 have no effect.
- R8: If the NAND flag of chip select 2 is set, its window 0x2000_0000–0x27FF_FFFF selects the SRAM with offset = address mod 4 KB. This holds even when its CF flag is also set.
- R9: Dynamic controller 0 decodes 0x4000_0000–0x4FFF_FFFF and controller 1 decodes 0x5000_0000–0x6FFF_FFFF. The offset is the address minus the window base.
- R10: Any address at or above 0x8000_0000 sets the error flag.
- R11: The outputs show the decision for an address presented with the valid strobe high, one cycle after that edge. They stay unchanged while the strobe is low.
- R12: The boot-mode input is captured only during reset. Changing it afterwards has no effect on decoding.
- R13: At most one select bit is high. When the error flag is high, no select bit is high and the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_nand_i | input | 1 | Boot mode: 0 = ROM boot, 1 = NAND boot (SRAM); sampled during reset |
| req_valid_i | input | 1 | Strobe: decode this cycle's address |
| req_addr_i | input | 32 | Byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cs_nand_i | input | 6 | Per static chip select: routed to the NAND controller |
| cs_cf_i | input | 6 | Per static chip select: routed to the CF controller |
| tgt_sel_o | output | 11 | One-hot target select (encoding in R2) |
| local_ofs_o | output | 29 | Offset inside the selected target |
| dec_err_o | output | 1 | Access rejected |

## Verification
A vector table covers every window at its first and last byte, and addresses well past the real storage of both on-chip memories. These show whether the folding uses the right size for each memory. The same chip-select address is presented with no flags, with a NAND flag, with a CF flag and with both flags set. This separates the mirror path from the blocking path and the priority between them. Flags placed on a neighbouring chip select, or on chip select 0 and 1, show that the flag index is decoded correctly. A second reset in NAND boot mode, followed by a change of the boot input, shows which target the boot window reaches and when the mode is captured. The writes that are allowed are told apart from the write to ROM that is rejected.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int ADDR_W    = 32;
    localparam int OFS_W     = 29;
    localparam int CS_COUNT  = 6;
    localparam int N_TGT     = 11;

    // Select bit positions (R2)
    localparam logic [3:0] T_ROM     = 4'd0;
    localparam logic [3:0] T_SRAM    = 4'd1;
    localparam logic [3:0] T_CS_BASE = 4'd2;
    localparam logic [3:0] T_DMC0    = 4'd8;
    localparam logic [3:0] T_DMC1    = 4'd9;
    localparam logic [3:0] T_PERI    = 4'd10;
    localparam logic [3:0] T_NONE    = 4'd15;

    localparam logic [ADDR_W-1:0] DMC1_BASE = 32'h5000_0000;

    typedef enum logic [2:0] {
        RG_BOOT,
        RG_IROM,
        RG_ISRAM,
        RG_STATIC,
        RG_DMC0,
        RG_DMC1,
        RG_PERI,
        RG_HOLE
    } region_e;

    typedef struct packed {
        logic [N_TGT-1:0] sel;
        logic [OFS_W-1:0] ofs;
        logic             err;
    } dec_state_t;

endpackage

// File: rtl/sad_region_map.sv
module sad_region_map
    import sad_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [2:0]        cs_idx
);

    always_comb begin
        region = RG_HOLE;
        if (!addr[31]) begin
            unique case (addr[30:28])
                3'd0: begin
                    if (!addr[27])     region = RG_BOOT;
                    else if (addr[26]) region = RG_ISRAM;
                    else               region = RG_IROM;
                end
                3'd1, 3'd2, 3'd3: region = RG_STATIC;
                3'd4:             region = RG_DMC0;
                3'd5, 3'd6:       region = RG_DMC1;
                default:          region = RG_PERI;
            endcase
        end
    end

    // 128 MB windows from 0x1000_0000: addr[29:27] = 2 for the first one
    assign cs_idx = addr[29:27] - 3'd2;

endmodule

// File: rtl/sad_cs_guard.sv
module sad_cs_guard
    import sad_pkg::*;
#(
    parameter int FIRST_GUARDED = 2,
    parameter int MIRROR_CS     = 2
) (
    input  logic [2:0]          cs_idx,
    input  logic [CS_COUNT-1:0] nand_flag,
    input  logic [CS_COUNT-1:0] cf_flag,
    output logic                blocked,
    output logic                mirror
);

    logic [CS_COUNT-1:0] block_vec;
    logic [CS_COUNT-1:0] mirror_vec;

    for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
        if (g >= FIRST_GUARDED) begin : g_guarded
            assign block_vec[g] = nand_flag[g] | cf_flag[g];
        end else begin : g_free
            assign block_vec[g] = 1'b0;
        end
        if (g == MIRROR_CS) begin : g_mirror
            assign mirror_vec[g] = nand_flag[g];
        end else begin : g_plain
            assign mirror_vec[g] = 1'b0;
        end
    end

    always_comb begin
        blocked = 1'b0;
        mirror  = 1'b0;
        if (int'(cs_idx) < CS_COUNT) begin
            blocked = block_vec[cs_idx];
            mirror  = mirror_vec[cs_idx];
        end
    end

endmodule

// File: rtl/sad_offset_fold.sv
module sad_offset_fold
    import sad_pkg::*;
#(
    parameter int ROM_LOG2    = 15,
    parameter int SRAM_LOG2   = 12,
    parameter int CS_WIN_LOG2 = 27
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        tgt,
    output logic [OFS_W-1:0]  ofs
);

    localparam logic [ADDR_W-1:0] ROM_MASK  = (ADDR_W'(1) << ROM_LOG2) - 1;
    localparam logic [ADDR_W-1:0] SRAM_MASK = (ADDR_W'(1) << SRAM_LOG2) - 1;
    localparam logic [ADDR_W-1:0] CS_MASK   = (ADDR_W'(1) << CS_WIN_LOG2) - 1;
    localparam logic [ADDR_W-1:0] SEG_MASK  = 32'h0FFF_FFFF;

    logic [ADDR_W-1:0] wide;

    always_comb begin
        unique case (tgt)
            T_ROM:   wide = addr & ROM_MASK;
            T_SRAM:  wide = addr & SRAM_MASK;
            T_DMC0:  wide = addr & SEG_MASK;
            T_DMC1:  wide = addr - DMC1_BASE;
            T_PERI:  wide = addr & SEG_MASK;
            T_NONE:  wide = '0;
            default: wide = addr & CS_MASK;
        endcase
        ofs = wide[OFS_W-1:0];
    end

endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
    import sad_pkg::*;
#(
    parameter int ROM_LOG2    = 15,
    parameter int SRAM_LOG2   = 12,
    parameter int CS_WIN_LOG2 = 27
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boot_nand_i,
    input  logic                req_valid_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                req_write_i,
    input  logic [CS_COUNT-1:0] cs_nand_i,
    input  logic [CS_COUNT-1:0] cs_cf_i,
    output logic [N_TGT-1:0]    tgt_sel_o,
    output logic [OFS_W-1:0]    local_ofs_o,
    output logic                dec_err_o
);

    region_e          region;
    logic [2:0]       cs_idx;
    logic             cs_blocked;
    logic             cs_mirror;
    logic [3:0]       tgt;
    logic             bad;
    logic [OFS_W-1:0] fold_ofs;
    logic             boot_nand_d, boot_nand_q;
    dec_state_t       state_d, state_q;

    sad_region_map u_map (
        .addr   (req_addr_i),
        .region (region),
        .cs_idx (cs_idx)
    );

    sad_cs_guard u_guard (
        .cs_idx    (cs_idx),
        .nand_flag (cs_nand_i),
        .cf_flag   (cs_cf_i),
        .blocked   (cs_blocked),
        .mirror    (cs_mirror)
    );

    sad_offset_fold #(
        .ROM_LOG2    (ROM_LOG2),
        .SRAM_LOG2   (SRAM_LOG2),
        .CS_WIN_LOG2 (CS_WIN_LOG2)
    ) u_fold (
        .addr (req_addr_i),
        .tgt  (tgt),
        .ofs  (fold_ofs)
    );

    always_comb begin
        tgt = T_NONE;
        bad = 1'b0;
        unique case (region)
            RG_BOOT:  tgt = boot_nand_q ? T_SRAM : T_ROM;
            RG_IROM:  tgt = T_ROM;
            RG_ISRAM: tgt = T_SRAM;
            RG_STATIC: begin
                if (cs_mirror)       tgt = T_SRAM;
                else if (cs_blocked) bad = 1'b1;
                else                 tgt = T_CS_BASE + {1'b0, cs_idx};
            end
            RG_DMC0:  tgt = T_DMC0;
            RG_DMC1:  tgt = T_DMC1;
            RG_PERI:  tgt = T_PERI;
            default:  bad = 1'b1;
        endcase
        if (tgt == T_ROM && req_write_i) begin
            bad = 1'b1;
        end
        if (bad) begin
            tgt = T_NONE;
        end
    end

    always_comb begin
        boot_nand_d = rst_n ? boot_nand_q : boot_nand_i;
        state_d     = state_q;
        if (req_valid_i) begin
            state_d.err = bad;
            state_d.sel = '0;
            state_d.ofs = '0;
            if (!bad) begin
                state_d.sel[tgt] = 1'b1;
                state_d.ofs      = fold_ofs;
            end
        end
    end

    always_ff @(posedge clk) begin
        boot_nand_q <= boot_nand_d;
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tgt_sel_o   = state_q.sel;
    assign local_ofs_o = state_q.ofs;
    assign dec_err_o   = state_q.err;

endmodule

// File: rtl/sad_checker.sv
module sad_checker
    import sad_pkg::*;
#(
    parameter int ROM_LOG2  = 15,
    parameter int SRAM_LOG2 = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic                req_write_i,
    input  logic [N_TGT-1:0]    tgt_sel_o,
    input  logic [OFS_W-1:0]    local_ofs_o,
    input  logic                dec_err_o
);

    // R13
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel_o));

    // R13
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> (tgt_sel_o == '0 && local_ofs_o == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ($stable(tgt_sel_o) && $stable(local_ofs_o) && $stable(dec_err_o)));

    // R4
    rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_addr_i[31:26] == 6'b000010) |=> dec_err_o);

    // R10
    high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_addr_i[31]) |=> dec_err_o);

    // R9
    dmc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_addr_i[31:28] == 4'h4) |=> (tgt_sel_o[8] && !dec_err_o));

    // R4
    rom_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel_o[0] |-> (local_ofs_o < OFS_W'(1 << ROM_LOG2)));

    // R5
    sram_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel_o[1] |-> (local_ofs_o < OFS_W'(1 << SRAM_LOG2)));

endmodule

bind sys_addr_decoder sad_checker #(
    .ROM_LOG2  (ROM_LOG2),
    .SRAM_LOG2 (SRAM_LOG2)
) u_sad_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .tgt_sel_o   (tgt_sel_o),
    .local_ofs_o (local_ofs_o),
    .dec_err_o   (dec_err_o)
);

// File: tb/tb_sys_addr_decoder.sv
module tb_sys_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_nand = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [5:0]  cs_nand = '0;
    logic [5:0]  cs_cf = '0;
    logic [10:0] tgt_sel;
    logic [28:0] local_ofs;
    logic        dec_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sys_addr_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_nand_i (boot_nand),
        .req_valid_i (req_valid),
        .req_addr_i  (req_addr),
        .req_write_i (req_write),
        .cs_nand_i   (cs_nand),
        .cs_cf_i     (cs_cf),
        .tgt_sel_o   (tgt_sel),
        .local_ofs_o (local_ofs),
        .dec_err_o   (dec_err)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        w;
        logic [5:0]  nf;
        logic [5:0]  cf;
        logic [3:0]  t;   // 15 = error expected
        logic [28:0] o;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h0000_1234, 1'b0, 6'h00, 6'h00, 4'd0,  29'h0000_1234},
        '{32'h0700_9ABC, 1'b0, 6'h00, 6'h00, 4'd0,  29'h0000_1ABC},
        '{32'h0000_0010, 1'b1, 6'h00, 6'h00, 4'd15, 29'h0},
        '{32'h0800_8004, 1'b0, 6'h00, 6'h00, 4'd0,  29'h0000_0004},
        '{32'h0BFF_FFFF, 1'b0, 6'h00, 6'h00, 4'd0,  29'h0000_7FFF},
        '{32'h0900_0000, 1'b1, 6'h00, 6'h00, 4'd15, 29'h0},
        '{32'h0C00_0FFF, 1'b1, 6'h00, 6'h00, 4'd1,  29'h0000_0FFF},
        '{32'h0FFF_F001, 1'b0, 6'h00, 6'h00, 4'd1,  29'h0000_0001},
        '{32'h1000_0000, 1'b0, 6'h00, 6'h00, 4'd2,  29'h0},
        '{32'h17FF_FFFF, 1'b1, 6'h00, 6'h00, 4'd2,  29'h07FF_FFFF},
        '{32'h1800_0040, 1'b0, 6'h03, 6'h03, 4'd3,  29'h0000_0040},
        '{32'h2000_0100, 1'b0, 6'h00, 6'h00, 4'd4,  29'h0000_0100},
        '{32'h2000_2345, 1'b1, 6'h04, 6'h00, 4'd1,  29'h0000_0345},
        '{32'h2000_2345, 1'b0, 6'h00, 6'h04, 4'd15, 29'h0},
        '{32'h2800_0008, 1'b0, 6'h00, 6'h00, 4'd5,  29'h0000_0008},
        '{32'h2800_0008, 1'b0, 6'h08, 6'h00, 4'd15, 29'h0},
        '{32'h3000_0000, 1'b0, 6'h00, 6'h10, 4'd15, 29'h0},
        '{32'h3000_0001, 1'b0, 6'h00, 6'h20, 4'd6,  29'h0000_0001},
        '{32'h3FFF_FFFC, 1'b1, 6'h00, 6'h00, 4'd7,  29'h07FF_FFFC},
        '{32'h3800_0000, 1'b0, 6'h20, 6'h00, 4'd15, 29'h0},
        '{32'h4000_0000, 1'b0, 6'h00, 6'h00, 4'd8,  29'h0},
        '{32'h4FFF_FFFF, 1'b1, 6'h00, 6'h00, 4'd8,  29'h0FFF_FFFF},
        '{32'h5000_0000, 1'b0, 6'h00, 6'h00, 4'd9,  29'h0},
        '{32'h6FFF_FFFF, 1'b1, 6'h00, 6'h00, 4'd9,  29'h1FFF_FFFF},
        '{32'h7000_0010, 1'b0, 6'h00, 6'h00, 4'd10, 29'h0000_0010},
        '{32'h7FFF_FFFF, 1'b1, 6'h00, 6'h00, 4'd10, 29'h0FFF_FFFF},
        '{32'h8000_0000, 1'b0, 6'h00, 6'h00, 4'd15, 29'h0},
        '{32'hFFFF_FFFF, 1'b1, 6'h00, 6'h00, 4'd15, 29'h0},
        '{32'h2000_0100, 1'b0, 6'h04, 6'h04, 4'd1,  29'h0000_0100}
    };

    function automatic string req_of(int i);
        case (i)
            0, 1:           return "R3";
            2, 3, 4, 5:     return "R4";
            6, 7:           return "R5";
            8, 9, 11, 14:   return "R6";
            17, 18:         return "R6";
            10, 13, 15, 16: return "R7";
            19:             return "R7";
            12, 28:         return "R8";
            20, 21, 22, 23: return "R9";
            24, 25:         return "R2";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [10:0] es, logic [28:0] eo, logic ee);
        checks++;
        if (tgt_sel !== es || local_ofs !== eo || dec_err !== ee) begin
            errors++;
            $display("FAIL %s: sel=%h ofs=%h err=%b expected sel=%h ofs=%h err=%b",
                     tag, tgt_sel, local_ofs, dec_err, es, eo, ee);
        end
    endtask

    // drive on a falling edge, register on the rising edge, sample on the next falling edge
    task automatic access(logic [31:0] a, logic w, logic [5:0] nf, logic [5:0] cf);
        @(negedge clk);
        req_addr  = a;
        req_write = w;
        cs_nand   = nf;
        cs_cf     = cf;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n     = 1'b0;
        boot_nand = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R1: reset state
        check("R1", 11'h0, 29'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].a, VECS[i].w, VECS[i].nf, VECS[i].cf);
            if (VECS[i].t == 4'd15) check(req_of(i), 11'h0, 29'h0, 1'b1);
            else                    check(req_of(i), 11'(1) << VECS[i].t, VECS[i].o, 1'b0);
        end

        // R11: new address without the strobe leaves the result unchanged
        access(32'h7000_0010, 1'b0, 6'h00, 6'h00);
        check("R11", 11'h400, 29'h10, 1'b0);
        @(negedge clk);
        req_addr = 32'h8000_0000;
        repeat (2) @(negedge clk);
        check("R11", 11'h400, 29'h10, 1'b0);

        // R1: reset in mid-run clears a held result
        do_reset(1'b1);
        check("R1", 11'h0, 29'h0, 1'b0);

        // R3: NAND boot sends the boot window to SRAM, folded to 4 KB
        access(32'h0000_5678, 1'b0, 6'h00, 6'h00);
        check("R3", 11'h002, 29'h678, 1'b0);
        access(32'h0000_0004, 1'b1, 6'h00, 6'h00);
        check("R3", 11'h002, 29'h004, 1'b0);

        // R12: boot input changes after reset are ignored
        @(negedge clk);
        boot_nand = 1'b0;
        access(32'h0000_0020, 1'b0, 6'h00, 6'h00);
        check("R12", 11'h002, 29'h020, 1'b0);
        access(32'h0000_0020, 1'b1, 6'h00, 6'h00);
        check("R12", 11'h002, 29'h020, 1'b0);

        // R4: direct ROM write is still rejected in NAND boot mode
        access(32'h0800_0000, 1'b1, 6'h00, 6'h00);
        check("R4", 11'h0, 29'h0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule